// File: doc/BRIEF.md
# Fractional-Second Real-Time Counter with Alarm

This block keeps wall-clock time inside a chip. It runs on a fast bus clock and advances on a slow clock-enable pulse that arrives once per period of a 32 kHz reference. The count is held as one binary value. The upper part holds whole seconds and the lower part holds the fraction of a second. By default these are a 32-bit seconds part and a 15-bit fraction, so the count is 47 bits wide. Software writes either part through separate write strobes that a register front end has already decoded and synchronized.

The block does not start counting by itself. Two conditions must both hold: the enable bit in the control word is set, and the seconds part has been written at least once since reset. A write of zero is enough for the second condition.

An alarm value of the same width is compared against the count each time the count advances. On a match a sticky alarm flag is set in a small status word. The alarm interrupt output is asserted while that flag is set and the alarm interrupt enable bit is set. The status word also holds a non-valid flag, which is set out of reset, and a violation flag, which an external detector raises. Every flag in the status word is cleared by writing one to its bit.

Top module: `rtc_tick_core`

## Requirements
- R1: After reset the count is 0, the enable bit is 0, the interrupt enable is 0, the alarm seconds part is all ones and the alarm fraction is 0. The status word is 5'b00010 (only the non-valid flag at bit 1 is set), and the alarm interrupt output is 0.
- R2: While counting is allowed, each cycle with `tick_i` high adds one to the count. The fraction carries into the seconds part, and the full count wraps from all ones to zero.
- R3: A control write sets the enable bit from data bit 3. While the enable bit is 0, the count holds its value through any number of ticks.
- R4: The count does not advance until the seconds part has been written since reset, even if the value written is zero. A fraction write alone does not allow counting.
- R5: A seconds write loads the upper part and keeps the fraction. A fraction write loads the lower part and keeps the seconds. In a cycle that has both a write and a tick, the write is applied and the tick is dropped.
- R6: The alarm flag (status bit 4) is set at the clock edge where the count advances to a value equal to {alarm seconds, alarm fraction}. A write that loads the count directly to the alarm value does not set the flag.
- R7: The alarm flag stays set until a status write with data bit 4 set. If a match and that clear occur in the same cycle, the flag stays set.
- R8: `alarm_irq_o` is 1 exactly while the alarm flag is set and the interrupt enable (written from data bit 4 of an interrupt-enable write) is set.
- R9: A cycle with `viol_i` high sets both the violation flag (status bit 0) and the non-valid flag (status bit 1). A status write with one in bit 1 or bit 0 clears that flag. Writing zero to a flag bit leaves the flag unchanged, and a clear in the same cycle as `viol_i` loses to the set.
- R10: Alarm seconds and alarm fraction writes load their own parts only, and both parts are visible on `alm_sec_o` and `alm_frac_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per 32 kHz period |
| viol_i | input | 1 | Violation pulse from an external detector |
| wr_sec_i | input | 1 | Write strobe for the count seconds part |
| wr_frac_i | input | 1 | Write strobe for the count fraction |
| wr_alm_sec_i | input | 1 | Write strobe for the alarm seconds part |
| wr_alm_frac_i | input | 1 | Write strobe for the alarm fraction |
| wr_ctrl_i | input | 1 | Write strobe for the control word (enable at bit 3) |
| wr_ien_i | input | 1 | Write strobe for the interrupt enable (bit 4) |
| wr_stat_i | input | 1 | Write-one-to-clear strobe for the status word |
| wr_data_i | input | DATA_W | Write data shared by all strobes |
| sec_o | output | SEC_W | Count, seconds part |
| frac_o | output | FRAC_W | Count, fraction |
| alm_sec_o | output | SEC_W | Alarm, seconds part |
| alm_frac_o | output | FRAC_W | Alarm, fraction |
| ctrl_en_o | output | 1 | Enable bit |
| irq_en_o | output | 1 | Alarm interrupt enable |
| status_o | output | 5 | Status: bit 4 alarm, bit 1 non-valid, bit 0 violation, bits 3:2 zero |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest situation to reach from the ports is a match exactly at a carry boundary. Examples are the fraction rolling into the seconds part, or the whole count wrapping through zero just before it lands on the alarm. The bench builds the block with an 8-bit seconds part and a 4-bit fraction. It sweeps alarm values across the whole 12-bit range, and for each one it loads the count a few ticks short of the alarm. This places the expected match at every kind of boundary, and the flag is checked both on the tick before the match and on the matching tick. A separate sweep loads every count value and advances it, so every carry and wrap path is covered.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CTRL_EN_BIT = 3;
  localparam int unsigned IEN_ALM_BIT = 4;
  localparam int unsigned ST_ALM_BIT  = 4;
  localparam int unsigned ST_NV_BIT   = 1;
  localparam int unsigned ST_SV_BIT   = 0;
  localparam int unsigned ST_W        = 5;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     run_en_i,
  input  logic                     wr_sec_i,
  input  logic                     wr_frac_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic [SEC_W+FRAC_W-1:0]  cnt_o,
  output logic [SEC_W+FRAC_W-1:0]  cnt_nxt_o,
  output logic                     adv_o,
  output logic                     armed_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);
  // a write in the same cycle drops the tick
  assign adv_o     = tick_i & run_en_i & armed_q & ~wr_sec_i & ~wr_frac_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (adv_o) cnt_q <= cnt_nxt_o;
      if (wr_sec_i) begin
        cnt_q[CNT_W-1:FRAC_W] <= wr_data_i[SEC_W-1:0];
        armed_q               <= 1'b1;
      end
      if (wr_frac_i) cnt_q[FRAC_W-1:0] <= wr_data_i[FRAC_W-1:0];
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_alm_sec_i,
  input  logic                     wr_alm_frac_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     adv_i,
  input  logic [SEC_W+FRAC_W-1:0]  cnt_nxt_i,
  output logic [SEC_W+FRAC_W-1:0]  alm_o,
  output logic                     match_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;
  localparam logic [CNT_W-1:0] ALM_RST = {{SEC_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [CNT_W-1:0] alm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= ALM_RST;
    end else begin
      if (wr_alm_sec_i)  alm_q[CNT_W-1:FRAC_W] <= wr_data_i[SEC_W-1:0];
      if (wr_alm_frac_i) alm_q[FRAC_W-1:0]     <= wr_data_i[FRAC_W-1:0];
    end
  end

  // compare the value the count is about to take, only on an advance
  assign match_o = adv_i & (cnt_nxt_i == alm_q);
  assign alm_o   = alm_q;
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic              viol_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ien_i,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  logic alm_q;
  logic [1:0] vflag_q;  // [1]=non-valid, [0]=violation

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                alm_q <= 1'b0;
    else if (match_i)                           alm_q <= 1'b1;
    else if (wr_stat_i && wr_data_i[ST_ALM_BIT]) alm_q <= 1'b0;
  end

  for (genvar g = 0; g < 2; g++) begin : g_vflag
    localparam int unsigned BIT = (g == 1) ? ST_NV_BIT : ST_SV_BIT;
    localparam logic        RV  = (g == 1) ? 1'b1 : 1'b0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          vflag_q[g] <= RV;
      else if (viol_i)                      vflag_q[g] <= 1'b1;
      else if (wr_stat_i && wr_data_i[BIT]) vflag_q[g] <= 1'b0;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[ST_ALM_BIT] = alm_q;
    status_o[ST_NV_BIT]  = vflag_q[1];
    status_o[ST_SV_BIT]  = vflag_q[0];
  end

  assign irq_o = alm_q & ien_i;
endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              viol_i,
  input  logic              wr_sec_i,
  input  logic              wr_frac_i,
  input  logic              wr_alm_sec_i,
  input  logic              wr_alm_frac_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_ien_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SEC_W-1:0]  alm_sec_o,
  output logic [FRAC_W-1:0] alm_frac_o,
  output logic              ctrl_en_o,
  output logic              irq_en_o,
  output logic [4:0]        status_o,
  output logic              alarm_irq_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic             en_q;
  logic             ien_q;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_nxt_w;
  logic [CNT_W-1:0] alm_w;
  logic             adv_w;
  logic             armed_w;
  logic             match_w;
  logic [ST_W-1:0]  st_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (wr_ctrl_i) en_q  <= wr_data_i[CTRL_EN_BIT];
      if (wr_ien_i)  ien_q <= wr_data_i[IEN_ALM_BIT];
    end
  end

  rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_en_i  (en_q),
    .wr_sec_i  (wr_sec_i),
    .wr_frac_i (wr_frac_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_w),
    .cnt_nxt_o (cnt_nxt_w),
    .adv_o     (adv_w),
    .armed_o   (armed_w)
  );

  rtc_alarm #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_alm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_alm_sec_i  (wr_alm_sec_i),
    .wr_alm_frac_i (wr_alm_frac_i),
    .wr_data_i     (wr_data_i),
    .adv_i         (adv_w),
    .cnt_nxt_i     (cnt_nxt_w),
    .alm_o         (alm_w),
    .match_o       (match_w)
  );

  rtc_status #(.DATA_W(DATA_W)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (match_w),
    .viol_i    (viol_i),
    .wr_stat_i (wr_stat_i),
    .wr_data_i (wr_data_i),
    .ien_i     (ien_q),
    .status_o  (st_w),
    .irq_o     (alarm_irq_o)
  );

  assign sec_o      = cnt_w[CNT_W-1:FRAC_W];
  assign frac_o     = cnt_w[FRAC_W-1:0];
  assign alm_sec_o  = alm_w[CNT_W-1:FRAC_W];
  assign alm_frac_o = alm_w[FRAC_W-1:0];
  assign ctrl_en_o  = en_q;
  assign irq_en_o   = ien_q;
  assign status_o   = st_w;
endmodule

// File: rtl/rtc_tick_core_chk.sv
module rtc_tick_core_chk #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              viol_i,
  input logic              wr_sec_i,
  input logic              wr_frac_i,
  input logic              wr_stat_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [SEC_W-1:0]  sec_o,
  input logic [FRAC_W-1:0] frac_o,
  input logic              ctrl_en_o,
  input logic              irq_en_o,
  input logic [4:0]        status_o,
  input logic              alarm_irq_o,
  input logic              armed_w
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;
  logic [CNT_W-1:0] cnt;
  assign cnt = {sec_o, frac_o};

  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctrl_en_o && armed_w && !wr_sec_i && !wr_frac_i)
      |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_o && !wr_sec_i && !wr_frac_i) |=> $stable(cnt));

  assert_unwritten_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_w && !wr_sec_i && !wr_frac_i) |=> $stable(cnt));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && !(wr_stat_i && wr_data_i[4])) |=> status_o[4]);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && wr_data_i[4] && !tick_i) |=> !status_o[4]);

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_irq_o) |-> (irq_en_o && status_o[4]));

  assert_viol_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> (status_o[1] && status_o[0]));

  assert_nv_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && wr_data_i[1] && !viol_i) |=> !status_o[1]);
endmodule

bind rtc_tick_core rtc_tick_core_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .viol_i      (viol_i),
  .wr_sec_i    (wr_sec_i),
  .wr_frac_i   (wr_frac_i),
  .wr_stat_i   (wr_stat_i),
  .wr_data_i   (wr_data_i),
  .sec_o       (sec_o),
  .frac_o      (frac_o),
  .ctrl_en_o   (ctrl_en_o),
  .irq_en_o    (irq_en_o),
  .status_o    (status_o),
  .alarm_irq_o (alarm_irq_o),
  .armed_w     (armed_w)
);

// File: tb/sim_rtc_tick_core.sv
`timescale 1ns/1ps
module sim_rtc_tick_core;
  localparam int SW = 8;
  localparam int FW = 4;
  localparam int CW = SW + FW;
  localparam int MOD = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, viol = 0;
  logic w_sec = 0, w_frac = 0, w_asec = 0, w_afrac = 0, w_ctrl = 0, w_ien = 0, w_stat = 0;
  logic [31:0] wdata = '0;
  logic [SW-1:0] sec, asec;
  logic [FW-1:0] frac, afrac;
  logic en, ien, irq;
  logic [4:0] st;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_tick_core #(.SEC_W(SW), .FRAC_W(FW), .DATA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .viol_i(viol),
    .wr_sec_i(w_sec), .wr_frac_i(w_frac), .wr_alm_sec_i(w_asec), .wr_alm_frac_i(w_afrac),
    .wr_ctrl_i(w_ctrl), .wr_ien_i(w_ien), .wr_stat_i(w_stat), .wr_data_i(wdata),
    .sec_o(sec), .frac_o(frac), .alm_sec_o(asec), .alm_frac_o(afrac),
    .ctrl_en_o(en), .irq_en_o(ien), .status_o(st), .alarm_irq_o(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic longint cnt_now();
    return longint'({sec, frac});
  endfunction

  // strobe: 0 sec,1 frac,2 asec,3 afrac,4 ctrl,5 ien,6 stat
  task automatic wr(input int which, input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    w_sec = (which == 0); w_frac = (which == 1); w_asec = (which == 2);
    w_afrac = (which == 3); w_ctrl = (which == 4); w_ien = (which == 5); w_stat = (which == 6);
    @(negedge clk);
    {w_sec, w_frac, w_asec, w_afrac, w_ctrl, w_ien, w_stat} = '0;
    wdata = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(input int v);
    wr(0, 32'(v >> FW));
    wr(1, 32'(v & ((1 << FW) - 1)));
  endtask

  task automatic set_alarm(input int v);
    wr(2, 32'(v >> FW));
    wr(3, 32'(v & ((1 << FW) - 1)));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", cnt_now(), 0);
    chk("R1 enable", en, 0);
    chk("R1 ien", ien, 0);
    chk("R1 alarm sec", asec, (1 << SW) - 1);
    chk("R1 alarm frac", afrac, 0);
    chk("R1 status", st, 5'b00010);
    chk("R1 irq", irq, 0);

    // R4: enabled but never written -> frozen; fraction write does not arm
    wr(4, 32'h8);
    chk("R3 enable bit3", en, 1);
    wr(1, 32'h5);
    ticks(6);
    chk("R4 unarmed frozen", cnt_now(), 5);
    // R3: armed by zero seconds write, enable off -> frozen
    wr(4, 32'h0);
    wr(0, 32'h0);
    chk("R5 sec write keeps frac", cnt_now(), 5);
    ticks(7);
    chk("R3 disabled frozen", cnt_now(), 5);
    wr(4, 32'hF7);
    chk("R3 other bits no enable", en, 0);
    wr(4, 32'h8);
    ticks(7);
    chk("R2 advance after arm", cnt_now(), 12);

    // R5: frac write keeps seconds; write beats tick
    wr(0, 32'h3C);
    wr(1, 32'h9);
    chk("R5 frac write keeps sec", cnt_now(), (32'h3C << FW) | 9);
    @(negedge clk);
    tick = 1; w_frac = 1; wdata = 32'h2;
    @(negedge clk);
    tick = 0; w_frac = 0; wdata = 0;
    chk("R5 write wins over tick", cnt_now(), (32'h3C << FW) | 2);

    // R2 near-exhaustive sweep of start values
    for (int s = 0; s < MOD; s++) begin
      int n = (s % 5) + 1;
      load(s);
      ticks(n);
      chk("R2 sweep", cnt_now(), (s + n) % MOD);
    end

    // R10 alarm word independence
    wr(2, 32'hA5);
    chk("R10 alarm sec", asec, 8'hA5);
    chk("R10 alarm frac kept", afrac, 0);
    wr(3, 32'h7);
    chk("R10 alarm frac", afrac, 7);
    chk("R10 alarm sec kept", asec, 8'hA5);

    // R6: direct load to alarm value does not set flag
    set_alarm(100);
    wr(6, 32'h10);
    load(100);
    chk("R6 load no match", st[4], 0);

    // R6 alarm sweep across boundaries
    for (int a = 0; a < MOD; a += 13) begin
      int k = 1 + (a % 6);
      set_alarm(a);
      load((a - k + MOD) % MOD);
      wr(6, 32'h10);
      if (k > 1) begin
        ticks(k - 1);
        chk("R6 no early flag", st[4], 0);
      end
      ticks(1);
      chk("R6 flag at match", st[4], 1);
    end
    for (int a = MOD - 1; a < MOD + 2; a++) begin
      int av = a % MOD;
      set_alarm(av);
      load((av - 2 + MOD) % MOD);
      wr(6, 32'h10);
      ticks(2);
      chk("R6 wrap edge", st[4], 1);
    end

    // R7/R8 sticky, irq gating, clear
    ticks(9);
    chk("R7 sticky", st[4], 1);
    wr(6, 32'h0F);
    chk("R7 zero in bit4 keeps", st[4], 1);
    chk("R8 irq gated off", irq, 0);
    wr(5, 32'h10);
    chk("R8 irq on", irq, 1);
    wr(6, 32'h10);
    chk("R7 cleared", st[4], 0);
    chk("R8 irq follows flag", irq, 0);
    // R7 match and clear same cycle: set wins
    set_alarm(50);
    load(49);
    @(negedge clk);
    tick = 1; w_stat = 1; wdata = 32'h10;
    @(negedge clk);
    tick = 0; w_stat = 0; wdata = 0;
    chk("R7 set beats clear", st[4], 1);
    chk("R8 irq set", irq, 1);
    wr(5, 32'h0);
    chk("R8 ien cleared", irq, 0);

    // R9 validity and violation flags
    wr(6, 32'h2);
    chk("R9 nv cleared", st, 5'b10000);
    @(negedge clk); viol = 1; @(negedge clk); viol = 0;
    chk("R9 viol sets", st, 5'b10011);
    wr(6, 32'h1);
    chk("R9 sv clear only", st, 5'b10010);
    @(negedge clk); viol = 1; w_stat = 1; wdata = 32'h3;
    @(negedge clk); viol = 0; w_stat = 0; wdata = 0;
    chk("R9 viol beats clear", st, 5'b10011);
    wr(6, 32'h13);
    chk("R9 all cleared", st, 5'b00000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule